// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Modulation

This block drives infrared emitters from a list of marks and gaps supplied by a host. The host never streams a waveform. It deposits run-length entries into two slots. Each entry carries a 7-bit duration, counted in sample periods, a flag that selects mark (modulated) or gap (dark), and a flag that marks the final entry of a message. A start strobe makes the block play slot 0, then slot 1, then slot 0 again, and so on. Each time a slot is used up, the block raises a one-cycle refill interrupt so that the host can put the next entry into the slot that has just been freed.

During a mark the emitters carry a square carrier. Its period and high width are counted in 500 ns units. The high width is derived from a duty percentage, and a polarity control inverts the waveform. A zero carrier period gives a steady, unmodulated mark. A 2-bit enable mask gates the two emitter pins independently. When a run is longer than 127 samples, the host breaks it into several consecutive entries of the same kind, and the carrier phase continues across them. If a slot runs out and its partner is still empty, the block goes dark and reports an underrun.

Top module: `irtx_runlen`

## Requirements
- R1: After reset the block is idle: both pins are low, and the interrupt, busy and underrun outputs are low. The configuration is carrier period 32, duty 50 %, no inversion, sample period 50 µs and pin mask 2'b11.
- R2: A start strobe while idle with slot 0 filled plays slot 0, then the other slot, alternating. Each entry lasts max(duration,1) × sample_us × 2 × HALF_US_CYC clock cycles, so a zero duration lasts one sample period.
- R3: During a gap both pins are low. During a mark, carrier phase k counts clock cycles from the first cycle of a run of consecutive marks. The carrier unit is (k / HALF_US_CYC) mod period, so the phase continues across consecutive mark entries.
- R4: The high width is period / (100 / duty), raised to 1 if the result is 0. A mark pin is high while unit < high width. A carrier period of 0 gives a constant high mark.
- R5: With the invert control set, the modulated carrier is inverted (high while unit ≥ high width). It has no effect when the period is 0.
- R6: Mask bit 0 enables pin 0 and mask bit 1 enables pin 1. A mask write of zero, or one with any of bits 7:2 set, is ignored.
- R7: Each time an entry finishes, tx_irq is high for exactly one cycle: the first cycle after it. When the entry flagged as final finishes, busy falls on the same edge as that interrupt rises.
- R8: If a non-final entry finishes while the other slot is empty, busy falls, the pins go low and tx_underrun rises together with the interrupt. A start strobe with slot 0 empty sets tx_underrun without starting. tx_underrun is cleared by the next successful start.
- R9: A write to a slot that still holds an entry not yet fully played is ignored.
- R10: A configuration write sets the period and invert control. Its duty is taken only if it lies in 1..99, and its sample period only if it is at least 5. Configuration and mask writes are ignored while busy.
- R11: A start strobe while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_wr | input | 1 | Write strobe for one slot |
| ent_idx | input | 1 | Slot selected by the write |
| ent_dur | input | 7 | Duration in sample periods |
| ent_pulse | input | 1 | 1 = mark (carrier), 0 = gap |
| ent_last | input | 1 | Entry is the last of the message |
| tx_start | input | 1 | Start strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_period | input | 7 | Carrier period in 500 ns units, 0 = unmodulated |
| cfg_duty | input | 7 | Carrier duty in percent |
| cfg_invert | input | 1 | Carrier polarity inversion |
| cfg_sample_us | input | 7 | Sample period in microseconds |
| mask_wr | input | 1 | Pin mask write strobe |
| mask_in | input | 8 | Requested pin mask |
| ir_out | output | 2 | Emitter pins |
| tx_irq | output | 1 | Refill request, one cycle per finished entry |
| tx_busy | output | 1 | Sequence playing |
| tx_underrun | output | 1 | Sequence stopped on an empty slot |

## Verification
The assertions rely on the host touching configuration only through the write strobes, on carrier and sample settings that the block itself freezes while a sequence plays, and on a sample period of at least 5 µs. Together these keep every entry at least ten cycles long, so two refill interrupts are never adjacent. The stimulus writes each refill on the cycle after its interrupt, which is long before the freed slot's partner finishes, except where an underrun is the goal. It pokes configuration, mask and start only while the block is busy when it tests that those are ignored, and it keeps the duty and sample fields in range except where a rejection is being tested.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int DUR_W      = 7;
    localparam int CAR_W      = 7;
    localparam int SMP_W      = 7;
    localparam int MASK_IN_W  = 8;
    localparam int NUM_TX     = 2;

    localparam logic [CAR_W-1:0] DEF_PERIOD = CAR_W'(32);
    localparam logic [CAR_W-1:0] DEF_DUTY   = CAR_W'(50);
    localparam logic [CAR_W-1:0] MAX_DUTY   = CAR_W'(99);
    localparam logic [SMP_W-1:0] DEF_SAMPLE = SMP_W'(50);
    localparam logic [SMP_W-1:0] MIN_SAMPLE = SMP_W'(5);

    typedef struct packed {
        logic             pulse;
        logic             last;
        logic [DUR_W-1:0] dur;
    } rl_entry_t;

    typedef struct packed {
        logic [CAR_W-1:0] period;
        logic [CAR_W-1:0] high;
        logic             invert;
    } carrier_cfg_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_PLAY = 1'b1
    } seq_state_t;

    // High width from period and duty; duty is kept in 1..99 by the caller.
    function automatic logic [CAR_W-1:0] calc_high(input logic [CAR_W-1:0] per,
                                                   input logic [CAR_W-1:0] duty);
        logic [CAR_W-1:0] step;
        logic [CAR_W-1:0] h;
        step = CAR_W'(100) / duty;
        h    = per / step;
        if (h == '0) h = CAR_W'(1);
        return h;
    endfunction

    function automatic logic [DUR_W-1:0] dur_floor(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

endpackage

// File: rtl/irtx_cfg.sv
module irtx_cfg
    import irtx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  busy,
    input  logic                  cfg_wr,
    input  logic [CAR_W-1:0]      cfg_period,
    input  logic [CAR_W-1:0]      cfg_duty,
    input  logic                  cfg_invert,
    input  logic [SMP_W-1:0]      cfg_sample_us,
    input  logic                  mask_wr,
    input  logic [MASK_IN_W-1:0]  mask_in,
    output carrier_cfg_t          car_o,
    output logic [SMP_W-1:0]      sample_o,
    output logic [NUM_TX-1:0]     mask_o
);

    logic [CAR_W-1:0]  period_q;
    logic [CAR_W-1:0]  duty_q;
    logic              invert_q;
    logic [SMP_W-1:0]  sample_q;
    logic [NUM_TX-1:0] mask_q;

    logic duty_ok;
    logic sample_ok;
    logic mask_ok;

    assign duty_ok   = (cfg_duty != '0) && (cfg_duty <= MAX_DUTY);
    assign sample_ok = (cfg_sample_us >= MIN_SAMPLE);
    assign mask_ok   = (mask_in != '0) && (mask_in[MASK_IN_W-1:NUM_TX] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= DEF_PERIOD;
            duty_q   <= DEF_DUTY;
            invert_q <= 1'b0;
            sample_q <= DEF_SAMPLE;
            mask_q   <= '1;
        end else if (!busy) begin
            if (cfg_wr) begin
                period_q <= cfg_period;
                invert_q <= cfg_invert;
                if (duty_ok)   duty_q   <= cfg_duty;
                if (sample_ok) sample_q <= cfg_sample_us;
            end
            if (mask_wr && mask_ok) begin
                mask_q <= mask_in[NUM_TX-1:0];
            end
        end
    end

    always_comb begin
        car_o.period = period_q;
        car_o.high   = calc_high(period_q, duty_q);
        car_o.invert = invert_q;
    end

    assign sample_o = sample_q;
    assign mask_o   = mask_q;

    assert_mask_legal_R6: assert property (@(posedge clk) disable iff (rst)
        mask_q != '0);

    assert_sample_floor_R10: assert property (@(posedge clk) disable iff (rst)
        sample_q >= MIN_SAMPLE);

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(period_q) && $stable(duty_q) &&
                                   $stable(sample_q) && $stable(mask_q)));

    assert_high_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (period_q != '0) |-> (car_o.high != '0 && car_o.high <= period_q));

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
#(
    parameter int HALF_US_CYC = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  carrier_cfg_t cfg,
    output logic         wave
);

    localparam int HC_W = (HALF_US_CYC > 1) ? $clog2(HALF_US_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_US_CYC - 1);

    logic [HC_W-1:0]  hc_q;
    logic [CAR_W-1:0] unit_q;
    logic             unit_wrap;

    assign unit_wrap = (cfg.period == '0) || (unit_q == cfg.period - CAR_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc_q   <= '0;
            unit_q <= '0;
        end else if (hc_q == HC_LAST) begin
            hc_q   <= '0;
            unit_q <= unit_wrap ? '0 : unit_q + CAR_W'(1);
        end else begin
            hc_q <= hc_q + HC_W'(1);
        end
    end

    always_comb begin
        if (cfg.period == '0) wave = 1'b1;
        else                  wave = (unit_q < cfg.high) ^ cfg.invert;
    end

    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && cfg.period != '0) |-> (unit_q < cfg.period));

    assert_phase_clear_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (unit_q == '0 && hc_q == '0));

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
#(
    parameter int HALF_US_CYC = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ent_wr,
    input  logic             ent_idx,
    input  rl_entry_t        entry_in,
    input  logic             start,
    input  logic [SMP_W-1:0] sample_us,
    output logic             pulse_on,
    output logic             busy,
    output logic             irq,
    output logic             underrun
);

    localparam int CYC_PER_US = 2 * HALF_US_CYC;
    localparam int SPC_MAX    = ((1 << SMP_W) - 1) * CYC_PER_US;
    localparam int SPC_W      = $clog2(SPC_MAX + 1);

    rl_entry_t        slot_q [2];
    logic [1:0]       valid_q;
    logic             cur_q;
    seq_state_t       state_q;
    logic [DUR_W-1:0] rem_q;
    logic [SPC_W-1:0] scnt_q;
    logic             irq_q;
    logic             under_q;

    logic [SPC_W-1:0] spc;
    logic             sample_end;
    logic             entry_end;

    assign spc        = SPC_W'(sample_us) * SPC_W'(CYC_PER_US);
    assign sample_end = (scnt_q == spc - SPC_W'(1));
    assign entry_end  = (state_q == SQ_PLAY) && sample_end && (rem_q == DUR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++) slot_q[s] <= '0;
            valid_q <= '0;
            cur_q   <= 1'b0;
            state_q <= SQ_IDLE;
            rem_q   <= '0;
            scnt_q  <= '0;
            irq_q   <= 1'b0;
            under_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ent_wr && !valid_q[ent_idx]) begin
                slot_q[ent_idx]  <= entry_in;
                valid_q[ent_idx] <= 1'b1;
            end
            if (state_q == SQ_IDLE) begin
                if (start) begin
                    if (valid_q[0]) begin
                        state_q <= SQ_PLAY;
                        cur_q   <= 1'b0;
                        rem_q   <= dur_floor(slot_q[0].dur);
                        scnt_q  <= '0;
                        under_q <= 1'b0;
                    end else begin
                        under_q <= 1'b1;
                    end
                end
            end else if (sample_end) begin
                scnt_q <= '0;
                if (entry_end) begin
                    valid_q[cur_q] <= 1'b0;
                    irq_q          <= 1'b1;
                    if (slot_q[cur_q].last) begin
                        state_q <= SQ_IDLE;
                    end else if (valid_q[!cur_q]) begin
                        cur_q <= !cur_q;
                        rem_q <= dur_floor(slot_q[!cur_q].dur);
                    end else begin
                        state_q <= SQ_IDLE;
                        under_q <= 1'b1;
                    end
                end else begin
                    rem_q <= rem_q - DUR_W'(1);
                end
            end else begin
                scnt_q <= scnt_q + SPC_W'(1);
            end
        end
    end

    assign busy     = (state_q == SQ_PLAY);
    assign pulse_on = busy && slot_q[cur_q].pulse;
    assign irq      = irq_q;
    assign underrun = under_q;

    assert_play_held_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> valid_q[cur_q]);

    assert_rem_live_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem_q != '0));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_end_irq_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    assert_underrun_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> !busy);

endmodule

// File: rtl/irtx_runlen.sv
module irtx_runlen
    import irtx_pkg::*;
#(
    parameter int HALF_US_CYC = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ent_wr,
    input  logic        ent_idx,
    input  logic [6:0]  ent_dur,
    input  logic        ent_pulse,
    input  logic        ent_last,
    input  logic        tx_start,
    input  logic        cfg_wr,
    input  logic [6:0]  cfg_period,
    input  logic [6:0]  cfg_duty,
    input  logic        cfg_invert,
    input  logic [6:0]  cfg_sample_us,
    input  logic        mask_wr,
    input  logic [7:0]  mask_in,
    output logic [1:0]  ir_out,
    output logic        tx_irq,
    output logic        tx_busy,
    output logic        tx_underrun
);

    rl_entry_t         entry_in;
    carrier_cfg_t      car_cfg;
    logic [SMP_W-1:0]  sample_us;
    logic [NUM_TX-1:0] pin_mask;
    logic              pulse_on;
    logic              busy;
    logic              wave;

    assign entry_in = '{pulse: ent_pulse, last: ent_last, dur: ent_dur};

    irtx_cfg cfg_i (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy),
        .cfg_wr        (cfg_wr),
        .cfg_period    (cfg_period),
        .cfg_duty      (cfg_duty),
        .cfg_invert    (cfg_invert),
        .cfg_sample_us (cfg_sample_us),
        .mask_wr       (mask_wr),
        .mask_in       (mask_in),
        .car_o         (car_cfg),
        .sample_o      (sample_us),
        .mask_o        (pin_mask)
    );

    irtx_seq #(.HALF_US_CYC(HALF_US_CYC)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .ent_wr    (ent_wr),
        .ent_idx   (ent_idx),
        .entry_in  (entry_in),
        .start     (tx_start),
        .sample_us (sample_us),
        .pulse_on  (pulse_on),
        .busy      (busy),
        .irq       (tx_irq),
        .underrun  (tx_underrun)
    );

    irtx_carrier #(.HALF_US_CYC(HALF_US_CYC)) car_i (
        .clk  (clk),
        .rst  (rst),
        .run  (pulse_on),
        .cfg  (car_cfg),
        .wave (wave)
    );

    for (genvar g = 0; g < NUM_TX; g++) begin : g_pin
        assign ir_out[g] = pulse_on && wave && pin_mask[g];
    end

    assign tx_busy = busy;

    assert_idle_dark_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> (ir_out == '0));

endmodule

// File: tb/irtx_runlen_tb_top.sv
module irtx_runlen_tb_top;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       ent_wr, ent_idx, ent_pulse, ent_last, tx_start;
    logic [6:0] ent_dur;
    logic       cfg_wr, cfg_invert, mask_wr;
    logic [6:0] cfg_period, cfg_duty, cfg_sample_us;
    logic [7:0] mask_in;
    logic [1:0] ir_out;
    logic       tx_irq, tx_busy, tx_underrun;

    always #10 clk = ~clk;

    irtx_runlen #(.HALF_US_CYC(HALF)) dut_i (
        .clk(clk), .rst(rst),
        .ent_wr(ent_wr), .ent_idx(ent_idx), .ent_dur(ent_dur),
        .ent_pulse(ent_pulse), .ent_last(ent_last), .tx_start(tx_start),
        .cfg_wr(cfg_wr), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
        .cfg_invert(cfg_invert), .cfg_sample_us(cfg_sample_us),
        .mask_wr(mask_wr), .mask_in(mask_in),
        .ir_out(ir_out), .tx_irq(tx_irq), .tx_busy(tx_busy),
        .tx_underrun(tx_underrun)
    );

    int n_pass = 0;
    int n_total = 0;
    int cyc_cnt = 0;

    // model configuration
    int m_period = 32, m_duty = 50, m_sample = 50, m_mask = 3;
    bit m_pol = 1'b0;

    int e_dur [16];
    bit e_pls [16];
    int n_ent;

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_total++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_cnt);
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    function automatic int hi_w();
        int h;
        h = m_period / (100 / m_duty);
        return (h == 0) ? 1 : h;
    endfunction

    function automatic bit wave_at(input int k);
        int unit;
        if (m_period == 0) return 1'b1;
        unit = (k / HALF) % m_period;
        return (unit < hi_w()) ^ m_pol;
    endfunction

    task automatic set_cfg(input int p, input int d, input bit pol, input int s);
        cfg_wr = 1'b1; cfg_period = 7'(p); cfg_duty = 7'(d);
        cfg_invert = pol; cfg_sample_us = 7'(s);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_period = p; m_pol = pol;
        if (d >= 1 && d <= 99) m_duty = d;
        if (s >= 5) m_sample = s;
    endtask

    task automatic set_mask(input int m);
        mask_wr = 1'b1; mask_in = 8'(m);
        @(negedge clk);
        mask_wr = 1'b0;
        if (m != 0 && (m >> 2) == 0) m_mask = m;
    endtask

    task automatic put_entry(input int idx, input int dur, input bit pls, input bit lst);
        ent_wr = 1'b1; ent_idx = idx[0]; ent_dur = 7'(dur);
        ent_pulse = pls; ent_last = lst;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    // host-side splitting of long runs into 127-sample pieces
    task automatic push_run(input int total, input bit pls);
        int t = total;
        while (t > 127) begin
            e_dur[n_ent] = 127; e_pls[n_ent] = pls; n_ent++; t -= 127;
        end
        e_dur[n_ent] = t; e_pls[n_ent] = pls; n_ent++;
    endtask

    task automatic run_seq(input string req, input bit refill, input bit dup, input bit poke);
        int i = 0, c = 0, k = 0, mism = 0, len;
        bit done = 0, eb, ei, eu;
        logic [1:0] eo;
        put_entry(0, e_dur[0], e_pls[0], n_ent == 1);
        if (n_ent > 1) put_entry(1, e_dur[1], e_pls[1], n_ent == 2);
        if (dup) begin
            put_entry(0, 9, !e_pls[0], 1'b0);
            put_entry(1, 9, !e_pls[1], 1'b0);
        end
        tx_start = 1'b1;
        @(negedge clk);
        while (!done) begin
            ent_wr = 1'b0; tx_start = 1'b0; cfg_wr = 1'b0; mask_wr = 1'b0;
            ei = (c == 0 && i > 0);
            if (i == n_ent || (!refill && i == 2 && n_ent > 2)) begin
                eb = 1'b0; eu = (i != n_ent); eo = 2'b00; done = 1'b1;
            end else begin
                eb = 1'b1; eu = 1'b0;
                eo[0] = e_pls[i] && wave_at(k) && m_mask[0];
                eo[1] = e_pls[i] && wave_at(k) && m_mask[1];
            end
            if (ir_out !== eo || tx_busy !== eb || tx_irq !== ei || tx_underrun !== eu)
                mism++;
            if (!done) begin
                if (refill && ei && i + 1 < n_ent) begin
                    ent_wr = 1'b1; ent_idx = 1'((i + 1) % 2);
                    ent_dur = 7'(e_dur[i + 1]); ent_pulse = e_pls[i + 1];
                    ent_last = (i + 1 == n_ent - 1);
                end
                if (poke && i == 0 && c == 3) begin
                    // R11 / R10: start, config and mask pokes while busy
                    tx_start = 1'b1;
                    cfg_wr = 1'b1; cfg_period = 7'd5; cfg_duty = 7'd10;
                    cfg_invert = !m_pol; cfg_sample_us = 7'd9;
                    mask_wr = 1'b1; mask_in = 8'd1;
                end
                len = ((e_dur[i] == 0) ? 1 : e_dur[i]) * m_sample * 2 * HALF;
                k = e_pls[i] ? k + 1 : 0;
                c++;
                if (c == len) begin c = 0; i++; end
            end
            @(negedge clk);
        end
        ent_wr = 1'b0; tx_start = 1'b0; cfg_wr = 1'b0; mask_wr = 1'b0;
        check(mism == 0, req, mism, 0);
    endtask

    initial begin
        rst = 1'b1;
        ent_wr = 0; ent_idx = 0; ent_dur = 0; ent_pulse = 0; ent_last = 0;
        tx_start = 0; cfg_wr = 0; cfg_period = 0; cfg_duty = 0; cfg_invert = 0;
        cfg_sample_us = 0; mask_wr = 0; mask_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(ir_out == 2'b00 && !tx_busy && !tx_irq && !tx_underrun, "R1 reset outputs",
              {ir_out, tx_busy, tx_irq, tx_underrun}, 0);

        // R1: defaults observed through the waveform (period 32, 50 %, 50 us, mask 3)
        n_ent = 0; push_run(1, 1); push_run(1, 0); push_run(2, 1);
        run_seq("R1 default configuration", 1, 0, 0);

        // R2 R3 R4 R5: sweep of period, duty and polarity; includes a zero duration
        foreach (e_dur[x]) e_dur[x] = 0;
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 5; d++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    int per_tab [4] = '{0, 3, 7, 32};
                    int duty_tab [5] = '{1, 25, 50, 75, 99};
                    set_cfg(per_tab[p], duty_tab[d], pol[0], 5);
                    n_ent = 0;
                    push_run(3, 1); push_run(0, 1); push_run(2, 0);
                    push_run(4, 1); push_run(1, 0);
                    run_seq("R2 R3 R4 R5 sweep", 1, 0, 0);
                end
            end
        end

        // R3 R2: long runs split by the host, carrier continuous across pieces
        set_cfg(7, 50, 0, 5);
        n_ent = 0; push_run(300, 1); push_run(130, 0); push_run(2, 1);
        run_seq("R3 split long run", 1, 0, 0);

        // R6: single-pin masks and rejected masks
        set_mask(1);
        n_ent = 0; push_run(2, 1); push_run(1, 0);
        run_seq("R6 mask pin0", 1, 0, 0);
        set_mask(2);
        set_mask(0); set_mask(4); set_mask(8'h83);
        check(m_mask == 2, "R6 model mask", m_mask, 2);
        n_ent = 0; push_run(2, 1); push_run(1, 0);
        run_seq("R6 rejected masks leave pin1 only", 1, 0, 0);
        set_mask(3);

        // R10: out-of-range duty and sample are ignored, period taken
        set_cfg(9, 25, 0, 6);
        set_cfg(11, 0, 1, 4);
        set_cfg(11, 100, 1, 3);
        check(m_duty == 25 && m_sample == 6, "R10 model retention", m_duty, 25);
        n_ent = 0; push_run(3, 1); push_run(1, 0); push_run(2, 1);
        run_seq("R10 rejected fields", 1, 0, 0);

        // R9: writes to held slots are ignored
        n_ent = 0; push_run(2, 1); push_run(3, 0); push_run(1, 1);
        run_seq("R9 write to held slot", 1, 1, 0);

        // R11 R10: start/config/mask pokes while busy are ignored
        n_ent = 0; push_run(2, 1); push_run(1, 0); push_run(2, 1);
        run_seq("R11 start while busy", 1, 0, 1);
        n_ent = 0; push_run(3, 1); push_run(1, 0);
        run_seq("R10 config frozen while busy", 1, 0, 0);

        // R8: underrun when no refill arrives
        n_ent = 0; push_run(2, 1); push_run(1, 1); push_run(2, 0);
        run_seq("R8 underrun", 0, 0, 0);

        // R8: start with slot 0 empty
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        check(tx_underrun && !tx_busy && !tx_irq && ir_out == 2'b00,
              "R8 start on empty slot", {tx_underrun, tx_busy, tx_irq}, 4);

        // R8 R7: next run clears underrun and ends on the final entry
        set_cfg(0, 50, 1, 5);
        n_ent = 0; push_run(1, 1); push_run(2, 0); push_run(1, 1);
        run_seq("R7 R8 unmodulated run after underrun", 1, 0, 0);

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule